// File: doc/BRIEF.md
# Three-Turn Bunch-by-Bunch Transverse Damper Filter

This block turns a stream of transverse beam positions, one value per bunch per revolution from a single pickup, into a signed correction kick for that same bunch. For every bucket it keeps the positions seen on the two previous turns. When a new position arrives, it forms a weighted sum of the new value and those two older values. Three programmable coefficients set the weights, and through them the loop gain and the betatron phase delivered at the kicker. The coefficients are meant to sum to zero, so that a steady orbit offset produces no kick.

The filter output passes through a gain stage, a dead band and a saturating limiter before it leaves as a 12-bit kick. The bucket index travels with the kick. If the programmed coefficients do not cancel, the block raises a flag and sends zero kicks. A turn marker that arrives with the first bunch of each revolution lets the block hold its output at zero until three turns of history exist after reset.

Top module: `bunch_kick_fir3`

## Requirements
- R1: For a bucket with positions x0 (this turn), x1 (previous turn) and x2 (two turns back), the filter sum is A = coef_now*x0 + coef_prev*x1 + coef_old*x2. The scaled value is floor(A*kick_gain / 16), with kick_gain unsigned and 16 meaning unity.
- R2: Each bucket index keeps its own two-turn history. A sample for one bucket never changes the history of another bucket.
- R3: A sample accepted on pos_valid at a clock edge gives kick_valid, together with its kick_bucket and kick_value, after the third clock edge counted from that edge, and not earlier. kick_value is zero whenever kick_valid is low.
- R4: When coef_now + coef_prev + coef_old is not zero, coef_bad is high from the next clock edge and every kick_value is zero. History updates continue during this time.
- R5: When the magnitude of the scaled value is no greater than dead_band, the kick is zero.
- R6: A scaled value above 2047 gives a kick of 2047, and one below -2048 gives -2048. The kick never wraps.
- R7: The kick stays zero for every sample until the third turn_mark after reset has been seen. A turn_mark counts only together with pos_valid, and it counts for the sample that carries it.
- R8: While rst is high, kick_valid, kick_value and coef_bad are low. Reset clears all bucket histories to zero and clears the turn count.
- R9: With zero-sum coefficients, a bucket whose position is the same on three turns in a row gets a zero kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_valid | input | 1 | A position sample is present this cycle |
| pos_bucket | input | BKT_W (4) | Bucket index of the sample |
| pos_value | input | 16 | Signed transverse position |
| turn_mark | input | 1 | Sample is the first of a new revolution |
| coef_now | input | 12 | Signed weight for the current turn |
| coef_prev | input | 12 | Signed weight for the previous turn |
| coef_old | input | 12 | Signed weight for two turns back |
| kick_gain | input | 8 | Unsigned gain, 4 fractional bits |
| dead_band | input | 11 | Unsigned dead-band magnitude |
| kick_valid | output | 1 | A kick is present this cycle |
| kick_bucket | output | BKT_W (4) | Bucket the kick belongs to |
| kick_value | output | 12 | Signed, saturated kick |
| coef_bad | output | 1 | Coefficients do not sum to zero |

## Verification
The bench targets the third turn: a design that arms one turn early or one turn late puts a kick on the second turn or gives zero on the third. A design that shares history between buckets shows up when buckets with different position patterns are interleaved. The bench also drives filter sums far past full scale in both directions, where a wrapping limiter would flip the sign of the kick. It also checks a small negative sum at half gain, where truncation toward zero would give -1 in place of -2. The remaining checks cover a value exactly at the dead-band edge, coefficients that do not cancel (a missing guard would let a kick through), and a reset in mid-run, after which stale history or a kept turn count would produce an early kick.

// File: rtl/bkick_pkg.sv
package bkick_pkg;

    localparam int POS_W     = 16;
    localparam int COEF_W    = 12;
    localparam int KICK_W    = 12;
    localparam int GAIN_W    = 8;
    localparam int GAIN_FRAC = 4;
    localparam int DB_W      = KICK_W - 1;
    localparam int ACC_W     = POS_W + COEF_W + 2;
    localparam int SCL_W     = ACC_W + GAIN_W + 1;
    localparam int CSUM_W    = COEF_W + 2;

    typedef logic signed [POS_W-1:0]  pos_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [KICK_W-1:0] kick_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [SCL_W-1:0]  scl_t;
    typedef logic signed [CSUM_W-1:0] csum_t;

    localparam scl_t KICK_HI = scl_t'((1 <<< (KICK_W - 1)) - 1);
    localparam scl_t KICK_LO = scl_t'(-(1 <<< (KICK_W - 1)));

    // One bucket's three turns of position, carried from the history stage
    typedef struct packed {
        logic vld;
        logic arm;
        pos_t x0;
        pos_t x1;
        pos_t x2;
    } taps_t;

    function automatic logic coef_cancel(coef_t a, coef_t b, coef_t c);
        csum_t s;
        s = csum_t'(a) + csum_t'(b) + csum_t'(c);
        return (s == '0);
    endfunction

    // Dead band first, then clamp to the kick range
    function automatic kick_t shape_kick(scl_t v, logic [DB_W-1:0] db);
        scl_t mag;
        scl_t dbx;
        mag = (v < 0) ? -v : v;
        dbx = scl_t'({1'b0, db});
        if (mag <= dbx)     return '0;
        if (v > KICK_HI)    return kick_t'(KICK_HI[KICK_W-1:0]);
        if (v < KICK_LO)    return kick_t'(KICK_LO[KICK_W-1:0]);
        return kick_t'(v[KICK_W-1:0]);
    endfunction

endpackage

// File: rtl/bkick_history.sv
module bkick_history
    import bkick_pkg::*;
#(
    parameter int NBKT  = 16,
    parameter int BKT_W = $clog2(NBKT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [BKT_W-1:0] in_bkt,
    input  pos_t             in_pos,
    input  logic             in_mark,
    output taps_t            taps,
    output logic [BKT_W-1:0] taps_bkt
);

    localparam logic [1:0] ARMED = 2'd3;

    pos_t       hist1 [NBKT];
    pos_t       hist2 [NBKT];
    logic [1:0] turns_q;
    logic [1:0] turns_nxt;

    always_comb begin
        turns_nxt = turns_q;
        if (in_vld && in_mark && (turns_q != ARMED))
            turns_nxt = turns_q + 2'd1;
    end

    // Read-modify-write: old slots read, shifted and refilled in one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBKT; i++) begin
                hist1[i] <= '0;
                hist2[i] <= '0;
            end
        end else if (in_vld) begin
            hist1[in_bkt] <= in_pos;
            hist2[in_bkt] <= hist1[in_bkt];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            turns_q  <= '0;
            taps     <= '0;
            taps_bkt <= '0;
        end else begin
            turns_q  <= turns_nxt;
            taps.vld <= in_vld;
            taps.arm <= (turns_nxt == ARMED);
            taps.x0  <= in_pos;
            taps.x1  <= hist1[in_bkt];
            taps.x2  <= hist2[in_bkt];
            taps_bkt <= in_bkt;
        end
    end

endmodule

// File: rtl/bkick_mac.sv
module bkick_mac
    import bkick_pkg::*;
#(
    parameter int BKT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  taps_t            taps,
    input  logic [BKT_W-1:0] taps_bkt,
    input  coef_t            c_now,
    input  coef_t            c_prev,
    input  coef_t            c_old,
    output acc_t             acc,
    output logic             acc_vld,
    output logic             acc_arm,
    output logic [BKT_W-1:0] acc_bkt
);

    acc_t sum_c;

    always_comb begin
        sum_c = acc_t'(c_now)  * acc_t'(taps.x0)
              + acc_t'(c_prev) * acc_t'(taps.x1)
              + acc_t'(c_old)  * acc_t'(taps.x2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            acc_vld <= 1'b0;
            acc_arm <= 1'b0;
            acc_bkt <= '0;
        end else begin
            acc     <= sum_c;
            acc_vld <= taps.vld;
            acc_arm <= taps.arm;
            acc_bkt <= taps_bkt;
        end
    end

endmodule

// File: rtl/bkick_shaper.sv
module bkick_shaper
    import bkick_pkg::*;
#(
    parameter int BKT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic              acc_vld,
    input  logic              acc_arm,
    input  logic [BKT_W-1:0]  acc_bkt,
    input  logic [GAIN_W-1:0] gain,
    input  logic [DB_W-1:0]   db,
    input  logic              block,
    output logic              k_vld,
    output logic [BKT_W-1:0]  k_bkt,
    output kick_t             k_val
);

    scl_t  scaled;
    kick_t shaped;

    always_comb begin
        scaled = (scl_t'(acc) * scl_t'({1'b0, gain})) >>> GAIN_FRAC;
        shaped = shape_kick(scaled, db);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k_vld <= 1'b0;
            k_bkt <= '0;
            k_val <= '0;
        end else begin
            k_vld <= acc_vld;
            k_bkt <= acc_bkt;
            k_val <= (acc_vld && acc_arm && !block) ? shaped : '0;
        end
    end

endmodule

// File: rtl/bunch_kick_fir3.sv
module bunch_kick_fir3
    import bkick_pkg::*;
#(
    parameter int NBKT  = 16,
    parameter int BKT_W = $clog2(NBKT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pos_valid,
    input  logic [BKT_W-1:0]         pos_bucket,
    input  logic signed [POS_W-1:0]  pos_value,
    input  logic                     turn_mark,
    input  logic signed [COEF_W-1:0] coef_now,
    input  logic signed [COEF_W-1:0] coef_prev,
    input  logic signed [COEF_W-1:0] coef_old,
    input  logic [GAIN_W-1:0]        kick_gain,
    input  logic [DB_W-1:0]          dead_band,
    output logic                     kick_valid,
    output logic [BKT_W-1:0]         kick_bucket,
    output logic signed [KICK_W-1:0] kick_value,
    output logic                     coef_bad
);

    taps_t            taps;
    logic [BKT_W-1:0] taps_bkt;
    acc_t             acc;
    logic             acc_vld;
    logic             acc_arm;
    logic [BKT_W-1:0] acc_bkt;
    logic             coef_off;

    assign coef_off = !coef_cancel(coef_now, coef_prev, coef_old);

    always_ff @(posedge clk) begin
        if (rst) coef_bad <= 1'b0;
        else     coef_bad <= coef_off;
    end

    bkick_history #(.NBKT(NBKT), .BKT_W(BKT_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (pos_valid),
        .in_bkt   (pos_bucket),
        .in_pos   (pos_value),
        .in_mark  (turn_mark),
        .taps     (taps),
        .taps_bkt (taps_bkt)
    );

    bkick_mac #(.BKT_W(BKT_W)) u_mac (
        .clk      (clk),
        .rst      (rst),
        .taps     (taps),
        .taps_bkt (taps_bkt),
        .c_now    (coef_now),
        .c_prev   (coef_prev),
        .c_old    (coef_old),
        .acc      (acc),
        .acc_vld  (acc_vld),
        .acc_arm  (acc_arm),
        .acc_bkt  (acc_bkt)
    );

    bkick_shaper #(.BKT_W(BKT_W)) u_shape (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .acc_vld (acc_vld),
        .acc_arm (acc_arm),
        .acc_bkt (acc_bkt),
        .gain    (kick_gain),
        .db      (dead_band),
        .block   (coef_off),
        .k_vld   (kick_valid),
        .k_bkt   (kick_bucket),
        .k_val   (kick_value)
    );

endmodule

// File: rtl/bunch_kick_chk.sv
module bunch_kick_chk
    import bkick_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     pos_valid,
    input logic                     turn_mark,
    input logic [DB_W-1:0]          dead_band,
    input logic                     kick_valid,
    input logic signed [KICK_W-1:0] kick_value,
    input logic                     coef_bad
);

    logic [1:0]      marks_q;
    logic [KICK_W:0] kmag;

    always_ff @(posedge clk) begin
        if (rst)
            marks_q <= '0;
        else if (pos_valid && turn_mark && (marks_q != 2'd3))
            marks_q <= marks_q + 2'd1;
    end

    assign kmag = kick_value[KICK_W-1] ? -{kick_value[KICK_W-1], kick_value}
                                       :  {kick_value[KICK_W-1], kick_value};

    // R3: sample accepted now gives a kick three edges later
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        pos_valid |-> ##3 kick_valid);

    // R3: no kick value without a kick strobe
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !kick_valid |-> (kick_value == '0));

    // R4: a non-cancelling coefficient set silences the output
    a_r4_bad_silent: assert property (@(posedge clk) disable iff (rst)
        coef_bad |-> (kick_value == '0));

    // R5: a non-zero kick lies outside the dead band unless clamped
    a_r5_deadband: assert property (@(posedge clk) disable iff (rst)
        (kick_value != '0) |-> ((kmag > {2'b00, $past(dead_band)}) ||
                                (kmag >= ((1 << (KICK_W - 1)) - 1))));

    // R7: no kick before three turn marks
    a_r7_armed: assert property (@(posedge clk) disable iff (rst)
        (kick_value != '0) |-> (marks_q == 2'd3));

    // R8: reset clears the outputs
    a_r8_reset: assert property (@(posedge clk)
        rst |=> (!kick_valid && (kick_value == '0) && !coef_bad));

endmodule

bind bunch_kick_fir3 bunch_kick_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pos_valid  (pos_valid),
    .turn_mark  (turn_mark),
    .dead_band  (dead_band),
    .kick_valid (kick_valid),
    .kick_value (kick_value),
    .coef_bad   (coef_bad)
);

// File: tb/sim_bunch_kick_fir3.sv
module sim_bunch_kick_fir3;

    localparam int NB   = 16;
    localparam int BW   = 4;
    localparam int NVEC = 16;

    // Stimulus table: bucket, position, turn mark (four turns, four buckets)
    localparam int VB [NVEC] = '{0, 1, 2, 3, 0, 1, 2, 3, 0, 1, 2, 3, 0, 1, 2, 3};
    localparam int VP [NVEC] = '{100, -50, 300, 0, 120, -40, 300, 700,
                                 90, -80, 300, -700, 500, -2000, 300, 0};
    localparam int VM [NVEC] = '{1, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pos_valid = 1'b0;
    logic [BW-1:0]      pos_bucket = '0;
    logic signed [15:0] pos_value = '0;
    logic               turn_mark = 1'b0;
    logic signed [11:0] coef_now = 12'sd1;
    logic signed [11:0] coef_prev = -12'sd2;
    logic signed [11:0] coef_old = 12'sd1;
    logic [7:0]         kick_gain = 8'd16;
    logic [10:0]        dead_band = '0;
    logic               kick_valid;
    logic [BW-1:0]      kick_bucket;
    logic signed [11:0] kick_value;
    logic               coef_bad;

    int     n_chk = 0;
    int     n_bad = 0;
    longint mh1 [NB];
    longint mh2 [NB];
    int     mturns = 0;

    always #5 clk = ~clk;

    bunch_kick_fir3 #(.NBKT(NB), .BKT_W(BW)) u0 (
        .clk(clk), .rst(rst), .pos_valid(pos_valid), .pos_bucket(pos_bucket),
        .pos_value(pos_value), .turn_mark(turn_mark), .coef_now(coef_now),
        .coef_prev(coef_prev), .coef_old(coef_old), .kick_gain(kick_gain),
        .dead_band(dead_band), .kick_valid(kick_valid), .kick_bucket(kick_bucket),
        .kick_value(kick_value), .coef_bad(coef_bad)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint model_kick(longint a);
        longint s;
        longint m;
        s = (a * longint'(kick_gain)) >>> 4;
        m = (s < 0) ? -s : s;
        if (m <= longint'(dead_band)) return 0;
        if (s > 2047)  return 2047;
        if (s < -2048) return -2048;
        return s;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NB; i++) begin
            mh1[i] = 0;
            mh2[i] = 0;
        end
        mturns = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // Drive one sample, check the idle cycle before the kick, then the kick
    task automatic send(input int b, input int p, input int m, input string req);
        longint a;
        longint e;
        bit     okc;
        @(negedge clk);
        pos_valid  = 1'b1;
        pos_bucket = BW'(b);
        pos_value  = 16'(p);
        turn_mark  = m[0];
        okc = (longint'(coef_now) + longint'(coef_prev) + longint'(coef_old)) == 0;
        if (m != 0 && mturns < 3) mturns++;
        a = longint'(coef_now) * p + longint'(coef_prev) * mh1[b]
          + longint'(coef_old) * mh2[b];
        e = (mturns >= 3 && okc) ? model_kick(a) : 0;
        mh2[b] = mh1[b];
        mh1[b] = p;
        @(posedge clk);
        @(negedge clk);
        pos_valid = 1'b0;
        turn_mark = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R3", "kick_valid one cycle early", longint'(kick_valid), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R3", "kick_valid", longint'(kick_valid), 1);
        chk("R2", "kick_bucket", longint'(kick_bucket), b);
        chk(req, "kick_value", longint'(kick_value), e);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        model_clear();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R8: outputs low during reset
        chk("R8", "kick_valid in reset", longint'(kick_valid), 0);
        chk("R8", "kick_value in reset", longint'(kick_value), 0);
        chk("R8", "coef_bad in reset", longint'(coef_bad), 0);
        rst = 1'b0;

        // R1, R2, R7: interleaved buckets over four turns
        for (int i = 0; i < NVEC; i++)
            send(VB[i], VP[i], VM[i], (i < 8) ? "R7" : "R1");

        // R9: constant position on three turns gives no kick
        send(5, 1234, 0, "R9");
        send(5, 1234, 0, "R9");
        send(5, 1234, 0, "R9");

        // R1: half gain with a small negative sum rounds toward minus infinity
        kick_gain = 8'd8;
        send(10, -3, 0, "R1");
        kick_gain = 8'd16;

        // R5: exactly at the dead band is zero, just past it passes
        dead_band = 11'd30;
        send(6, 0, 0, "R5");
        send(6, 0, 0, "R5");
        send(6, 30, 0, "R5");
        send(7, 31, 0, "R5");
        dead_band = '0;

        // R6: clamp in both directions
        coef_now  = 12'sd100;
        coef_prev = -12'sd100;
        coef_old  = 12'sd0;
        send(8, 1000, 0, "R6");
        send(9, -1000, 0, "R6");
        send(12, 20, 0, "R6");

        // R4: non-cancelling coefficients raise the flag and silence the kick
        coef_now  = 12'sd1;
        coef_prev = 12'sd1;
        coef_old  = 12'sd0;
        @(negedge clk);
        @(negedge clk);
        chk("R4", "coef_bad", longint'(coef_bad), 1);
        send(11, 1000, 0, "R4");
        coef_now  = 12'sd1;
        coef_prev = -12'sd2;
        coef_old  = 12'sd1;
        @(negedge clk);
        @(negedge clk);
        chk("R4", "coef_bad cleared", longint'(coef_bad), 0);
        send(11, 1000, 0, "R4");

        // R8, R7: reset in mid-run clears history and the turn count
        do_reset();
        send(0, 10, 1, "R8");
        send(0, 20, 1, "R7");
        send(0, 40, 1, "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule